// File: doc/BRIEF.md
# Plug-and-Play Configuration Register Window

This block implements the configuration space of a multi-function I/O controller as seen through a two-byte host window. One byte of the window is an index port and the other is a data port. The host writes a register number to the index port, then reads or writes that register through the data port. Per-device registers act on whichever logical device is currently selected. Every device's activation bit, three I/O base addresses and IRQ number are exported as ports, so the device controllers that sit beside this block can decode them.

Access is locked after reset. While locked, bytes written to the index port go to a key matcher. Configuration mode opens only when four bytes arrive in the correct order. The last byte of the key depends on which of the two window base addresses the instance is strapped to. Configuration mode closes when the host writes a specific value to a global control register, not when it sends a second key. The host side is a synchronous strobe interface: a write strobe, a read strobe and a one-bit port select. Read data comes back one clock after the read strobe.

Top module: `pnp_cfg_window`

## Requirements
- R1: Port select 0 is the index port and port select 1 is the data port. Read data appears on `rd_data`, with `rd_valid` high, on the clock after `rd_en`. In configuration mode, a read of the index port returns the last index written.
- R2: While locked, writing 0x87, 0x01, 0x55 and then a final byte to the index port enters configuration mode. The final byte is 0x55 when `ALT_BASE`=0 (window at 0x2E) and 0xAA when `ALT_BASE`=1. With `ALT_BASE`=0, the sequence 0x87, 0x01, 0x55, 0xAA does not unlock.
- R3: A byte that does not match the expected key byte sends the matcher back to the start. If that byte is 0x87, it counts as the first key byte.
- R4: While locked, data port writes change no register, and reads of either port return 0xFF.
- R5: In configuration mode, writing 0x02 to register 0x02 leaves configuration mode. Writing any other value to register 0x02 leaves the mode unchanged.
- R6: Register 0x07 holds the logical device number and reads back as written. Per-device writes change only the selected device.
- R7: Bit 0 of register 0x30 sets the selected device's activation output. Register 0x30 reads back as {7'b0, active}.
- R8: Registers 0x60/0x61, 0x62/0x63 and 0x64/0x65 hold the high and low bytes of the first, second and third I/O base. The bases are exported on `dev_io0`, `dev_io1` and `dev_io2` (16 bits per device, device n at bits n*16 upward).
- R9: A base byte is ANDed with the selected device's alignment mask before it is stored, and readback returns the masked value. The masks are 0x0FF8 by default, 0x0FFC for the second base of devices 3 and 4, and 0x0FFF for both bases of device 5.
- R10: Register 0x70 holds the selected device's IRQ number. It is exported on `dev_irq` (8 bits per device) and reads back as written.
- R11: Device numbers 0x00 to 0x07 and 0x0A are implemented. When another number is selected, every per-device register reads as 0x00 and writes have no effect.
- R12: After reset, the block is locked, all devices are inactive, and all bases and IRQs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | High on the clock that carries read data |
| cfg_mode | output | 1 | Configuration mode is open |
| dev_active | output | NDEV | Activation bit of each device |
| dev_io0 | output | NDEV*16 | First I/O base of each device |
| dev_io1 | output | NDEV*16 | Second I/O base of each device |
| dev_io2 | output | NDEV*16 | Third I/O base of each device |
| dev_irq | output | NDEV*8 | IRQ number of each device |

## Verification
The bench attacks the key matcher with three bad sequences. The first is a broken sequence followed by a fresh key. A matcher that does not reset would unlock on the fresh key too early. The second has a repeated 0x87. A matcher that does not restart on 0x87 would stay locked. The third ends with the final byte meant for the other base address, and a design that accepts either final byte would open on it.

The bench writes all-ones base values and checks that the alignment bits are cleared, using the keyboard device's unmasked bases as a contrast. It writes to an unimplemented device number and checks that no activation output moves. It also checks that an exit write with the wrong value keeps the mode open, and that data port writes after a correct exit leave every device output unchanged.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

  localparam int BYTE_W = 8;
  localparam int BASE_W = 16;

  // unlock key, in arrival order
  localparam logic [7:0] KEY_B0     = 8'h87;
  localparam logic [7:0] KEY_B1     = 8'h01;
  localparam logic [7:0] KEY_B2     = 8'h55;
  localparam logic [7:0] KEY_LAST_A = 8'h55;
  localparam logic [7:0] KEY_LAST_B = 8'hAA;

  // register map
  localparam logic [7:0] RG_CTRL   = 8'h02;
  localparam logic [7:0] CTRL_EXIT = 8'h02;
  localparam logic [7:0] RG_SEL    = 8'h07;
  localparam logic [7:0] RG_ACT    = 8'h30;
  localparam logic [7:0] RG_B0_HI  = 8'h60;
  localparam logic [7:0] RG_B0_LO  = 8'h61;
  localparam logic [7:0] RG_B1_HI  = 8'h62;
  localparam logic [7:0] RG_B1_LO  = 8'h63;
  localparam logic [7:0] RG_B2_HI  = 8'h64;
  localparam logic [7:0] RG_B2_LO  = 8'h65;
  localparam logic [7:0] RG_IRQ    = 8'h70;

  // alignment mask per device and base slot
  function automatic logic [15:0] base_mask(input int dev, input int slot);
    if (dev == 5 && slot < 2)             return 16'h0FFF;
    if ((dev == 3 || dev == 4) && slot == 1) return 16'h0FFC;
    return 16'h0FF8;
  endfunction

endpackage

// File: rtl/pnp_key_unlock.sv
module pnp_key_unlock
  import pnp_cfg_pkg::*;
#(
  parameter bit ALT_BASE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       exit_req,
  output logic       cfg_mode
);

  localparam logic [7:0] KEY_LAST = ALT_BASE ? KEY_LAST_B : KEY_LAST_A;

  logic [1:0] step;
  logic [7:0] want;

  always_comb begin
    case (step)
      2'd0:    want = KEY_B0;
      2'd1:    want = KEY_B1;
      2'd2:    want = KEY_B2;
      default: want = KEY_LAST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= 2'd0;
      cfg_mode <= 1'b0;
    end else if (cfg_mode) begin
      step <= 2'd0;
      if (exit_req) cfg_mode <= 1'b0;
    end else if (key_wr) begin
      if (key_byte == want) begin
        if (step == 2'd3) begin
          cfg_mode <= 1'b1;
          step     <= 2'd0;
        end else begin
          step <= step + 2'd1;
        end
      end else if (key_byte == KEY_B0) begin
        step <= 2'd1;   // R3: a stray 0x87 restarts the key
      end else begin
        step <= 2'd0;
      end
    end
  end

  // R2: the mode opens only right after the final key byte
  a_r2_entry_on_key: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_mode) |-> ($past(key_wr) && $past(key_byte) == KEY_LAST));

  // R5: an exit request in mode closes it on the next edge
  a_r5_exit_closes: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && exit_req) |=> !cfg_mode);

endmodule

// File: rtl/pnp_dev_slot.sv
module pnp_dev_slot
  import pnp_cfg_pkg::*;
#(
  parameter logic [15:0] MASK0 = 16'h0FF8,
  parameter logic [15:0] MASK1 = 16'h0FF8,
  parameter logic [15:0] MASK2 = 16'h0FF8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [7:0]  reg_idx,
  input  logic [7:0]  wdata,
  output logic        active,
  output logic [15:0] io0,
  output logic [15:0] io1,
  output logic [15:0] io2,
  output logic [7:0]  irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      io0    <= '0;
      io1    <= '0;
      io2    <= '0;
      irq    <= '0;
    end else if (wr) begin
      case (reg_idx)
        RG_ACT:   active     <= wdata[0];
        RG_B0_HI: io0[15:8]  <= wdata & MASK0[15:8];
        RG_B0_LO: io0[7:0]   <= wdata & MASK0[7:0];
        RG_B1_HI: io1[15:8]  <= wdata & MASK1[15:8];
        RG_B1_LO: io1[7:0]   <= wdata & MASK1[7:0];
        RG_B2_HI: io2[15:8]  <= wdata & MASK2[15:8];
        RG_B2_LO: io2[7:0]   <= wdata & MASK2[7:0];
        RG_IRQ:   irq        <= wdata;
        default:  ;
      endcase
    end
  end

  // R6: a slot that receives no write keeps every output
  a_r6_unselected_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable({active, io0, io1, io2, irq}));

endmodule

// File: rtl/pnp_cfg_window.sv
module pnp_cfg_window
  import pnp_cfg_pkg::*;
#(
  parameter int          NDEV      = 11,
  parameter logic [10:0] IMPL      = 11'b100_1111_1111,
  parameter bit          ALT_BASE  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 port_sel,
  input  logic [7:0]           wr_data,
  output logic [7:0]           rd_data,
  output logic                 rd_valid,
  output logic                 cfg_mode,
  output logic [NDEV-1:0]      dev_active,
  output logic [NDEV*16-1:0]   dev_io0,
  output logic [NDEV*16-1:0]   dev_io1,
  output logic [NDEV*16-1:0]   dev_io2,
  output logic [NDEV*8-1:0]    dev_irq
);

  localparam int IDW = $clog2(NDEV);

  logic [7:0]     index_q;
  logic [7:0]     ldn_q;
  logic           idx_wr, dat_wr, exit_req, sel_ok;
  logic [IDW-1:0] sel;
  logic [7:0]     data_rd;

  logic        act_a [NDEV];
  logic [15:0] io0_a [NDEV];
  logic [15:0] io1_a [NDEV];
  logic [15:0] io2_a [NDEV];
  logic [7:0]  irq_a [NDEV];

  assign idx_wr   = wr_en && !port_sel;
  assign dat_wr   = wr_en && port_sel && cfg_mode;
  assign exit_req = dat_wr && index_q == RG_CTRL && wr_data == CTRL_EXIT;
  assign sel      = ldn_q[IDW-1:0];
  assign sel_ok   = (ldn_q < 8'(NDEV)) && IMPL[sel];

  pnp_key_unlock #(.ALT_BASE(ALT_BASE)) u_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (idx_wr && !cfg_mode),
    .key_byte (wr_data),
    .exit_req (exit_req),
    .cfg_mode (cfg_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else if (cfg_mode) begin
      if (idx_wr) index_q <= wr_data;
      if (dat_wr && index_q == RG_SEL) ldn_q <= wr_data;
    end
  end

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    if (IMPL[i]) begin : g_impl
      pnp_dev_slot #(
        .MASK0 (base_mask(i, 0)),
        .MASK1 (base_mask(i, 1)),
        .MASK2 (base_mask(i, 2))
      ) u_slot (
        .clk     (clk),
        .rst     (rst),
        .wr      (dat_wr && sel_ok && sel == IDW'(i)),
        .reg_idx (index_q),
        .wdata   (wr_data),
        .active  (act_a[i]),
        .io0     (io0_a[i]),
        .io1     (io1_a[i]),
        .io2     (io2_a[i]),
        .irq     (irq_a[i])
      );
    end else begin : g_none
      assign act_a[i] = 1'b0;
      assign io0_a[i] = '0;
      assign io1_a[i] = '0;
      assign io2_a[i] = '0;
      assign irq_a[i] = '0;
    end
    assign dev_active[i]      = act_a[i];
    assign dev_io0[i*16 +: 16] = io0_a[i];
    assign dev_io1[i*16 +: 16] = io1_a[i];
    assign dev_io2[i*16 +: 16] = io2_a[i];
    assign dev_irq[i*8 +: 8]   = irq_a[i];
  end

  always_comb begin
    data_rd = 8'h00;
    if (index_q == RG_SEL) begin
      data_rd = ldn_q;
    end else if (sel_ok) begin
      case (index_q)
        RG_ACT:   data_rd = {7'b0, act_a[sel]};
        RG_B0_HI: data_rd = io0_a[sel][15:8];
        RG_B0_LO: data_rd = io0_a[sel][7:0];
        RG_B1_HI: data_rd = io1_a[sel][15:8];
        RG_B1_LO: data_rd = io1_a[sel][7:0];
        RG_B2_HI: data_rd = io2_a[sel][15:8];
        RG_B2_LO: data_rd = io2_a[sel][7:0];
        RG_IRQ:   data_rd = irq_a[sel];
        default:  data_rd = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= 8'hFF;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (!cfg_mode)      rd_data <= 8'hFF;
        else if (!port_sel) rd_data <= index_q;
        else                rd_data <= data_rd;
      end
    end
  end

  // R4: reads while locked return all ones
  a_r4_locked_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !cfg_mode) |=> (rd_valid && rd_data == 8'hFF));

  // R4: data port writes while locked leave device state alone
  a_r4_locked_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_sel && !cfg_mode) |=>
      $stable({dev_active, dev_io0, dev_io1, dev_io2, dev_irq}));

  // R1: read data is flagged exactly one clock after the strobe
  a_r1_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

endmodule

// File: tb/pnp_cfg_window_tb.sv
module pnp_cfg_window_tb;

  localparam int NDEV = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rd_valid, cfg_mode;
  logic [NDEV-1:0]    dev_active;
  logic [NDEV*16-1:0] dev_io0, dev_io1, dev_io2;
  logic [NDEV*8-1:0]  dev_irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;   // 250 MHz

  pnp_cfg_window u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .cfg_mode(cfg_mode), .dev_active(dev_active), .dev_io0(dev_io0),
    .dev_io1(dev_io1), .dev_io2(dev_io2), .dev_irq(dev_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; port_sel = p; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic p, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; port_sel = p;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    wr(1'b0, a); wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    wr(1'b0, a); rd(1'b1, exp, tag);
  endtask

  task automatic key(input logic [7:0] last);
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, last);
  endtask

  // monitor: compare each read result against the queue head
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1: unexpected read data %0h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R12: reset state
    check("R12 mode", cfg_mode, 0);
    check("R12 active", dev_active, 0);
    check("R12 io0", dev_io0[31:0], 0);
    check("R12 irq", dev_irq[31:0], 0);
    rd(1'b0, 8'hFF, "R4 locked index read");
    // R4: locked data write ignored
    wr(1'b1, 8'h55);
    rd(1'b1, 8'hFF, "R4 locked data read");
    // R3: broken key then correct tail does not unlock
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h12);
    wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    check("R3 broken key", cfg_mode, 0);
    // R2: final byte of the other base does not unlock
    key(8'hAA);
    check("R2 wrong final byte", cfg_mode, 0);
    // R3: repeated 0x87 restarts and then unlocks
    wr(1'b0, 8'h87);
    key(8'h55);
    check("R3 R2 unlock", cfg_mode, 1);
    // R6, R7: select device 5 and activate
    reg_wr(8'h07, 8'h05);
    reg_rd(8'h07, 8'h05, "R6 select readback");
    rd(1'b0, 8'h07, "R1 index readback");
    reg_wr(8'h30, 8'hFF);
    check("R7 active dev5", dev_active, 11'h020);
    reg_rd(8'h30, 8'h01, "R7 act readback");
    // R8, R9: keyboard base, 0x0FFF mask
    reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34);
    check("R8 R9 dev5 io0", dev_io0[5*16 +: 16], 16'h0234);
    reg_rd(8'h60, 8'h02, "R8 hi readback");
    reg_rd(8'h61, 8'h34, "R8 lo readback");
    // R9: 8-byte aligned base of device 1, IRQ
    reg_wr(8'h07, 8'h01);
    reg_wr(8'h60, 8'hFF); reg_wr(8'h61, 8'hFF);
    check("R9 dev1 io0", dev_io0[1*16 +: 16], 16'h0FF8);
    reg_rd(8'h61, 8'hF8, "R9 masked readback");
    reg_wr(8'h70, 8'h04);
    check("R10 dev1 irq", dev_irq[1*8 +: 8], 8'h04);
    reg_rd(8'h70, 8'h04, "R10 irq readback");
    check("R6 dev5 untouched", dev_io0[5*16 +: 16], 16'h0234);
    // R9: second base of device 4, third base of device 7
    reg_wr(8'h07, 8'h04);
    reg_wr(8'h62, 8'hFF); reg_wr(8'h63, 8'hFF);
    check("R9 dev4 io1", dev_io1[4*16 +: 16], 16'h0FFC);
    reg_wr(8'h07, 8'h07);
    reg_wr(8'h64, 8'hAB); reg_wr(8'h65, 8'hCD);
    check("R8 R9 dev7 io2", dev_io2[7*16 +: 16], 16'h0BC8);
    // R11: unimplemented device 8
    reg_wr(8'h07, 8'h08);
    reg_wr(8'h30, 8'h01); reg_wr(8'h60, 8'h03);
    check("R11 no activation", dev_active, 11'h020);
    reg_rd(8'h30, 8'h00, "R11 act reads zero");
    reg_rd(8'h60, 8'h00, "R11 base reads zero");
    // device 0x0A is implemented
    reg_wr(8'h07, 8'h0A);
    reg_wr(8'h30, 8'h01);
    check("R11 dev10 active", dev_active, 11'h420);
    // R5: wrong exit value keeps mode, correct one leaves
    reg_wr(8'h02, 8'h01);
    check("R5 stays", cfg_mode, 1);
    reg_wr(8'h02, 8'h02);
    check("R5 exit", cfg_mode, 0);
    // R4: after exit, data writes do nothing
    wr(1'b1, 8'h00);
    check("R4 active held", dev_active, 11'h420);
    rd(1'b1, 8'hFF, "R4 data read after exit");
    repeat (4) @(posedge clk);
    #1;
    check("R1 all reads returned", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule